// File: doc/BRIEF.md
# Lock-Protected ADC Register Front-End

This block is the digital control side of a multiplexed analog-to-digital converter. Software reaches it over a small register bus with four word addresses. The block holds an input-routing code that selects which multiplexer path feeds the converter. It sends a one-cycle start strobe to the converter and captures the sample that comes back with the converter's done strobe.

The routing register is protected. It changes only when a write of the exact word 0xAA to the key register comes directly before it. Any other write in between cancels the unlock. A bus read of the result register returns the current ready flag and sample, and that same read asks for a new conversion.

The block paces every conversion start. A start waits for a settling window after the routing code changes, and two starts are always at least one minimum conversion period apart. Both windows come from the `CLK_HZ` parameter and from a pacing select input. The slow setting gives 2 ms of settling and about 925 conversions per second. The fast setting gives 500 µs of settling and about 3750 conversions per second.

Top module: `adcfe_top`

## Requirements
- R1: After a synchronous reset, the routing code is zero and the unlock is cleared. The result word reads zero and `conv_start` is low. The settle and period timers are idle, so a first result read starts a conversion on the next clock edge.
- R2: A write of the full word 0x000000AA to address 0 arms a one-shot unlock. Reads do not disturb it. The next bus write, if it goes to address 1, loads `bus_wdata[11:0]` into the routing code, which drives `conv_chan` and reads back zero-extended from address 1. The write that is accepted uses up the unlock.
- R3: A write to address 1 that the unlock did not come directly before leaves the routing code unchanged.
- R4: A write to address 0 with any value other than 0x000000AA leaves the routing register locked. A write to any address other than 0 also re-locks it.
- R5: A read puts its data on `bus_rdata` in the cycle after the read. For address 2 the word has the ready flag in bit 31, zeros in bits 30:16 and the sample in bits 15:0. Each such read requests one conversion. Several requests that arrive before the start is issued merge into one.
- R6: A start is a single-cycle `conv_start` pulse, issued on the first clock edge at which a request is pending, no conversion is in flight and both timers are idle. That same edge clears the ready flag and the sample field to zero, so the old result is discarded.
- R7: A `conv_done` pulse while a conversion is in flight captures `conv_sample` and sets the ready flag. A `conv_done` pulse when no conversion is in flight has no effect.
- R8: Two starts are at least ceil(CLK_HZ/3750) clock edges apart when `pace_sel`=0, and at least ceil(CLK_HZ/925) apart when `pace_sel`=1. A request that arrives early is held until the period ends. It is not dropped.
- R9: After a routing write is accepted, no start occurs until ceil(CLK_HZ/2000) clock edges have passed when `pace_sel`=0, or ceil(CLK_HZ/500) when `pace_sel`=1. Every accepted write, even one with the same code, restarts this window.
- R10: `pace_sel`=0 selects the divide-by-4 windows and `pace_sel`=1 selects the divide-by-16 windows. The setting is sampled at the moment a window starts.
- R11: The sample field is two's complement. Sign-extending bit 15 of a read result gives back the converter's signed value.
- R12: A read of address 0 or address 3 returns zero. `bus_rdata` is zero in any cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word address: 0 key, 1 routing, 2 result, 3 unused |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pace_sel | input | 1 | 0: divide-by-4 timing, 1: divide-by-16 timing |
| conv_start | output | 1 | One-cycle conversion start strobe |
| conv_chan | output | 12 | Current routing code for the multiplexer |
| conv_done | input | 1 | Converter done strobe |
| conv_sample | input | 16 | Converter sample, valid with `conv_done` |

## Verification
The unlock state is internal and cannot be read directly. A stale or sticky unlock shows up as a routing code that does or does not change on the readback from address 1 issued right after the write in question. A settle or period counter that is off by even one cycle moves the edge of the `conv_start` pulse, and a reference model that steps with the design catches that at the first start after the window. A wrong in-flight flag shows up in two places: a stray done pulse overwrites the captured sample seen on the next result read, or a start fires while a conversion is still running.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;

    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 32;
    localparam int SAMPLE_W = 16;
    localparam int CHAN_W   = 12;

    typedef enum logic [ADDR_W-1:0] {
        REG_KEY    = 2'd0,
        REG_ROUTE  = 2'd1,
        REG_RESULT = 2'd2,
        REG_SPARE  = 2'd3
    } reg_sel_e;

    localparam logic [DATA_W-1:0] UNLOCK_WORD = 32'h0000_00AA;

    typedef enum logic {
        PACE_DIV4  = 1'b0,
        PACE_DIV16 = 1'b1
    } pace_e;

    // reciprocal of each window, in hertz
    localparam int unsigned SETTLE_RATE_FAST = 2000;  // 500 us
    localparam int unsigned SETTLE_RATE_SLOW = 500;   // 2 ms
    localparam int unsigned CONV_RATE_FAST   = 3750;
    localparam int unsigned CONV_RATE_SLOW   = 925;

    localparam int TMR_SETTLE = 0;
    localparam int TMR_PERIOD = 1;
    localparam int TMR_NUM    = 2;

    typedef struct packed {
        logic                ready;
        logic [SAMPLE_W-1:0] sample;
    } result_t;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [DATA_W-1:0] pack_result(input result_t r);
        return {r.ready, {(DATA_W-1-SAMPLE_W){1'b0}}, r.sample};
    endfunction

endpackage

// File: rtl/adcfe_lockgate.sv
module adcfe_lockgate
    import adcfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [CHAN_W-1:0] route,
    output logic              load
);

    logic armed_q;

    // only the write directly after the key may touch the routing code
    assign load = wr && (addr == REG_ROUTE) && armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            route   <= '0;
        end else begin
            if (wr) begin
                armed_q <= (addr == REG_KEY) && (wdata == UNLOCK_WORD);
            end
            if (load) begin
                route <= wdata[CHAN_W-1:0];
            end
        end
    end

    assert_locked_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && (addr == REG_ROUTE) && !armed_q) |=> $stable(route));

    assert_other_write_relocks_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && (addr != REG_KEY)) |=> !armed_q);

endmodule

// File: rtl/adcfe_pacer.sv
module adcfe_pacer
    import adcfe_pkg::*;
#(
    parameter int unsigned CLK_HZ = 1_000_000
) (
    input  logic               clk,
    input  logic               rst,
    input  pace_e              pace,
    input  logic [TMR_NUM-1:0] trig,
    output logic [TMR_NUM-1:0] busy
);

    localparam int unsigned SET_F = ceil_div(CLK_HZ, SETTLE_RATE_FAST);
    localparam int unsigned SET_S = ceil_div(CLK_HZ, SETTLE_RATE_SLOW);
    localparam int unsigned PER_F = ceil_div(CLK_HZ, CONV_RATE_FAST);
    localparam int unsigned PER_S = ceil_div(CLK_HZ, CONV_RATE_SLOW);
    localparam int unsigned MAXV  = max2(max2(SET_F, SET_S), max2(PER_F, PER_S));
    localparam int          CW    = $clog2(MAXV + 1);

    for (genvar k = 0; k < TMR_NUM; k++) begin : g_tmr
        localparam int unsigned LEN_F = (k == TMR_SETTLE) ? SET_F : PER_F;
        localparam int unsigned LEN_S = (k == TMR_SETTLE) ? SET_S : PER_S;
        localparam logic [CW-1:0] RLD_F = CW'(LEN_F - 1);
        localparam logic [CW-1:0] RLD_S = CW'(LEN_S - 1);

        logic [CW-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (trig[k]) begin
                cnt_q <= (pace == PACE_DIV16) ? RLD_S : RLD_F;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end

        assign busy[k] = (cnt_q != '0);
    end

endmodule

// File: rtl/adcfe_convctl.sv
module adcfe_convctl
    import adcfe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic                allow,
    input  logic                done,
    input  logic [SAMPLE_W-1:0] din,
    output logic                fire,
    output logic                start,
    output result_t             res
);

    logic pend_q;
    logic busy_q;

    assign fire = pend_q && allow && !busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            busy_q <= 1'b0;
            start  <= 1'b0;
            res    <= '0;
        end else begin
            start <= fire;
            if (req) begin
                pend_q <= 1'b1;
            end else if (fire) begin
                pend_q <= 1'b0;
            end
            if (fire) begin
                busy_q <= 1'b1;
                res    <= '0;
            end else if (done && busy_q) begin
                busy_q     <= 1'b0;
                res.ready  <= 1'b1;
                res.sample <= din;
            end
        end
    end

    assert_start_discards_R6: assert property (@(posedge clk) disable iff (rst)
        start |-> (res == '0));

    assert_ready_from_done_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(res.ready) |-> $past(done));

endmodule

// File: rtl/adcfe_top.sv
module adcfe_top
    import adcfe_pkg::*;
#(
    parameter int unsigned CLK_HZ = 1_000_000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                pace_sel,
    output logic                conv_start,
    output logic [CHAN_W-1:0]   conv_chan,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] conv_sample
);

    logic               route_load;
    logic               start_fire;
    logic               result_req;
    logic [TMR_NUM-1:0] tmr_trig;
    logic [TMR_NUM-1:0] tmr_busy;
    result_t            result;

    adcfe_lockgate u_lock (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .route (conv_chan),
        .load  (route_load)
    );

    assign tmr_trig[TMR_SETTLE] = route_load;
    assign tmr_trig[TMR_PERIOD] = start_fire;

    adcfe_pacer #(.CLK_HZ(CLK_HZ)) u_pace (
        .clk  (clk),
        .rst  (rst),
        .pace (pace_e'(pace_sel)),
        .trig (tmr_trig),
        .busy (tmr_busy)
    );

    assign result_req = bus_rd && (bus_addr == REG_RESULT);

    adcfe_convctl u_conv (
        .clk   (clk),
        .rst   (rst),
        .req   (result_req),
        .allow (tmr_busy == '0),
        .done  (conv_done),
        .din   (conv_sample),
        .fire  (start_fire),
        .start (conv_start),
        .res   (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                REG_ROUTE:  bus_rdata <= DATA_W'(conv_chan);
                REG_RESULT: bus_rdata <= pack_result(result);
                default:    bus_rdata <= '0;
            endcase
        end else begin
            bus_rdata <= '0;
        end
    end

    assert_start_single_R6: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    assert_no_start_settling_R9: assert property (@(posedge clk) disable iff (rst)
        tmr_busy[TMR_SETTLE] |=> !conv_start);

    assert_no_start_in_period_R8: assert property (@(posedge clk) disable iff (rst)
        tmr_busy[TMR_PERIOD] |=> !conv_start);

    assert_idle_read_zero_R12: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));

endmodule

// File: tb/adcfe_top_tb_top.sv
module adcfe_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int unsigned TB_HZ = 100_000;
    // windows worked out by hand for TB_HZ
    localparam int SET_F = 50;
    localparam int SET_S = 200;
    localparam int PER_F = 27;
    localparam int PER_S = 109;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic        bus_rd;
    logic [31:0] bus_rdata;
    logic        pace_sel;
    logic        conv_start;
    logic [11:0] conv_chan;
    logic        conv_done;
    logic [15:0] conv_sample;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wr_edge = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adcfe_top #(.CLK_HZ(TB_HZ)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rd      (bus_rd),
        .bus_rdata   (bus_rdata),
        .pace_sel    (pace_sel),
        .conv_start  (conv_start),
        .conv_chan   (conv_chan),
        .conv_done   (conv_done),
        .conv_sample (conv_sample)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- converter stub ----------------
    int st_lat = 0;
    int st_num = 0;
    int st_val = 0;
    int stub_last = 0;
    int stray_cnt = 0;
    int stray_seen = 0;

    always @(negedge clk) begin
        if (rst) begin
            st_lat = 0;
            conv_done = 1'b0;
            conv_sample = '0;
        end else begin
            conv_done = 1'b0;
            if (st_lat > 0) begin
                st_lat = st_lat - 1;
                if (st_lat == 0) begin
                    conv_done = 1'b1;
                    conv_sample = 16'(st_val);
                    stub_last = st_val;
                end
            end else if (stray_cnt != stray_seen) begin
                stray_seen = stray_cnt;
                conv_done = 1'b1;
                conv_sample = 16'h1234;
            end
            if (conv_start) begin
                st_lat = 4;
                st_val = (st_num % 2 == 1) ? (300 + st_num) : (-1000 - 37 * st_num);
                st_num = st_num + 1;
            end
        end
    end

    // ---------------- reference model ----------------
    logic        m_armed, m_pend, m_busy, m_ready, m_start;
    logic [11:0] m_sw;
    logic [15:0] m_sample;
    logic [31:0] m_rdata;
    int          m_set, m_per;

    always @(posedge clk) begin
        logic fire;
        logic load;
        if (rst) begin
            m_armed = 0; m_pend = 0; m_busy = 0; m_ready = 0; m_start = 0;
            m_sw = 0; m_sample = 0; m_rdata = 0; m_set = 0; m_per = 0;
        end else begin
            fire = m_pend && (m_set == 0) && (m_per == 0) && !m_busy;
            load = bus_wr && (bus_addr == 2'd1) && m_armed;
            if (bus_rd && bus_addr == 2'd1) m_rdata = {20'd0, m_sw};
            else if (bus_rd && bus_addr == 2'd2) m_rdata = {m_ready, 15'd0, m_sample};
            else m_rdata = 32'd0;
            if (bus_wr) m_armed = (bus_addr == 2'd0) && (bus_wdata == 32'h0000_00AA);
            if (load) begin
                m_sw = bus_wdata[11:0];
                m_set = (pace_sel ? SET_S : SET_F) - 1;
            end else if (m_set > 0) m_set = m_set - 1;
            if (fire) m_per = (pace_sel ? PER_S : PER_F) - 1;
            else if (m_per > 0) m_per = m_per - 1;
            if (fire) begin
                m_ready = 0; m_sample = 0;
            end else if (conv_done && m_busy) begin
                m_ready = 1; m_sample = conv_sample;
            end
            if (fire) m_busy = 1;
            else if (conv_done) m_busy = 0;
            if (bus_rd && bus_addr == 2'd2) m_pend = 1;
            else if (fire) m_pend = 0;
            m_start = fire;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks = checks + 3;
            if (conv_start !== m_start) begin
                errors++;
                $display("FAIL R6 conv_start at edge %0d: got %b expected %b", cyc, conv_start, m_start);
            end
            if (conv_chan !== m_sw) begin
                errors++;
                $display("FAIL R2 conv_chan: got %h expected %h", conv_chan, m_sw);
            end
            if (bus_rdata !== m_rdata) begin
                errors++;
                $display("FAIL R5 bus_rdata: got %h expected %h", bus_rdata, m_rdata);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        wr_edge = cyc + 1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_start(output int e);
        e = -1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (conv_start) begin
                e = cyc;
                break;
            end
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] rd;
        int e1, e2;
        rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_wdata = '0; bus_rd = 0; pace_sel = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(conv_start == 1'b0, "R1 conv_start after reset", conv_start, 0);
        check(conv_chan == 12'h0, "R1 conv_chan after reset", conv_chan, 0);
        bus_read(2'd1, rd);
        check(rd == 32'h0, "R1 routing readback", rd, 0);
        bus_read(2'd2, rd);
        check(rd == 32'h0, "R1 result readback", rd, 0);

        // R3: write without unlock ignored
        bus_write(2'd1, 32'h608);
        bus_read(2'd1, rd);
        check(rd == 32'h0, "R3 locked write", rd, 0);

        // R2: unlock, then write accepted
        bus_write(2'd0, 32'hAA);
        bus_write(2'd1, 32'h608);
        bus_read(2'd1, rd);
        check(rd == 32'h608, "R2 unlocked write", rd, 32'h608);
        check(conv_chan == 12'h608, "R2 conv_chan", conv_chan, 12'h608);

        // R4: intervening write to another address re-locks
        bus_write(2'd0, 32'hAA);
        bus_write(2'd3, 32'h5);
        bus_write(2'd1, 32'h680);
        bus_read(2'd1, rd);
        check(rd == 32'h608, "R4 intervening write", rd, 32'h608);

        // R4: wrong key stays locked
        bus_write(2'd0, 32'h55);
        bus_write(2'd1, 32'h680);
        bus_read(2'd1, rd);
        check(rd == 32'h608, "R4 wrong key", rd, 32'h608);

        // R2: unlock is one-shot
        bus_write(2'd0, 32'hAA);
        bus_write(2'd1, 32'h640);
        bus_write(2'd1, 32'h620);
        bus_read(2'd1, rd);
        check(rd == 32'h640, "R2 one-shot unlock", rd, 32'h640);

        // R9 settle window, fast pacing
        idle(300);
        bus_write(2'd0, 32'hAA);
        bus_write(2'd1, 32'h610);
        bus_read(2'd2, rd);
        wait_start(e1);
        check(e1 - wr_edge == SET_F, "R9 fast settle", e1 - wr_edge, SET_F);

        // R8 minimum period, fast pacing, deferred request
        idle(10);
        bus_read(2'd2, rd);
        wait_start(e2);
        check(e2 - e1 == PER_F, "R8 fast period", e2 - e1, PER_F);

        // R6 start discards previous result
        bus_read(2'd2, rd);
        check(rd == 32'h0, "R6 discarded result", rd, 0);

        // R7 stray done ignored, then R5 / R11 result word
        idle(300);
        stray_cnt++;
        idle(5);
        bus_read(2'd2, rd);
        check(rd[31] == 1'b1, "R7 ready flag", rd[31], 1);
        check(rd[15:0] != 16'h1234, "R7 stray done ignored", rd[15:0], 16'(stub_last));
        check(rd[30:16] == 15'h0 && rd[15:0] == 16'(stub_last), "R5 result word",
              rd, {1'b1, 15'h0, 16'(stub_last)});
        check(int'($signed(rd[15:0])) == stub_last, "R11 signed sample",
              int'($signed(rd[15:0])), stub_last);

        // R10 slow pacing: settle and period
        pace_sel = 1'b1;
        idle(300);
        bus_write(2'd0, 32'hAA);
        bus_write(2'd1, 32'h620);
        bus_read(2'd2, rd);
        wait_start(e1);
        check(e1 - wr_edge == SET_S, "R10 slow settle", e1 - wr_edge, SET_S);
        idle(10);
        bus_read(2'd2, rd);
        wait_start(e2);
        check(e2 - e1 == PER_S, "R10 slow period", e2 - e1, PER_S);

        // R12 key and spare addresses read zero
        bus_read(2'd0, rd);
        check(rd == 32'h0, "R12 key read", rd, 0);
        bus_read(2'd3, rd);
        check(rd == 32'h0, "R12 spare read", rd, 0);

        idle(300);
        finish_run();
    end

endmodule